// File: doc/BRIEF.md
# Configurable Single-Port Distributed RAM

This block is a small single-port memory meant for register-file, scratch-pad and lookup duties. It is built from a plain array with a combinational read. One address selects the word that is written and the word that is read. A write happens on the rising clock edge whenever the effective write enable is high. The block offers two read views of the addressed word. `rd_comb` follows the array with no clock latency. `rd_q` is the same word taken through an output register, plus an optional extra pipeline stage.

Build-time parameters set the following:
- the depth (a multiple of 16, from 16 to 65536 words) and the word width (1 to 1024 bits);
- whether address, data and write enable pass through input registers first;
- whether the write-enable input register obeys the input clock enable;
- whether the extra output stage is present;
- which of synchronous reset and clock enable takes precedence at the output;
- the word every location holds at start-up.

All controls are active-high.

Top module: `lutram_sp`

## Requirements
- R1: On a rising edge of `clk` with the effective write enable high, the effective data word is stored at the effective address. With the effective write enable low, the array is left unchanged.
- R2: `rd_comb` shows the stored word at the effective address in the same cycle. After an edge that writes the address being read, it shows the new word.
- R3: With `PIPE_EN`=0, `rd_q` takes the value `rd_comb` had just before an edge on which `oreg_ce` is high and no synchronous clear acts. On an edge that writes the read address, this is the old word.
- R4: With `PIPE_EN`=1, a second stage (same enable and clears) follows the first, so `rd_q` trails `rd_comb` by two enabled edges.
- R5: With `IN_REG`=1, the effective address and data are registered copies of `addr` and `din`. They load only on edges where `in_ce` is high and hold otherwise. With `IN_REG`=0, they are `addr` and `din` directly.
- R6: With `IN_REG`=1, the registered write enable loads `wr_en` on every edge when `WE_GATED`=0, and only on edges with `in_ce` high when `WE_GATED`=1.
- R7: When `oreg_ce` is low and no synchronous clear acts, every output stage holds its value.
- R8: With `SRST_PRIO`=PRIO_SRST_WINS, `oreg_srst` high at an edge clears all output stages to zero, whatever the state of `oreg_ce`.
- R9: With `SRST_PRIO`=PRIO_CE_GATES, `oreg_srst` clears the output stages only on edges where `oreg_ce` is high. Otherwise it is ignored.
- R10: `oreg_arst` high clears `rd_q` to zero at once, without waiting for a clock, and leaves the array contents unchanged.
- R11: Before any write, every location reads as `INIT_WORD`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Write clock and clock for all registers |
| in_ce | input | 1 | Clock enable for the input registers |
| addr | input | $clog2(DEPTH) | Read/write address |
| din | input | WIDTH | Write data |
| wr_en | input | 1 | Write enable |
| oreg_ce | input | 1 | Clock enable for the output stages |
| oreg_srst | input | 1 | Synchronous clear of the output stages |
| oreg_arst | input | 1 | Asynchronous clear of the output stages |
| rd_comb | output | WIDTH | Combinational read of the effective address |
| rd_q | output | WIDTH | Registered (optionally pipelined) read |

## Verification
The bench builds three copies, all 64 words by 16 bits, that share one stimulus stream:
- **Copy A** has bare inputs, a single output stage, a winning synchronous clear and a zero start-up word.
- **Copy B** has registered inputs with an ungated write-enable register, the extra pipeline stage, clock-enable-gated clear and a nonzero start-up word.
- **Copy C** has registered inputs with a gated write-enable register, one output stage, a winning clear and a third start-up word.

Together the copies reach both priority modes, both write-enable gating options, both latencies and held versus transparent addresses. Cases such as `in_ce` low with `wr_en` high therefore diverge visibly between B and C.

// File: rtl/lutram_pkg.sv
package lutram_pkg;

  // Which control wins at the output stages when both are asserted.
  typedef enum logic {
    PRIO_CE_GATES  = 1'b0,  // clear acts only with the enable high
    PRIO_SRST_WINS = 1'b1   // clear acts regardless of the enable
  } srst_prio_e;

  function automatic logic clear_hits(srst_prio_e prio, logic srst, logic ce);
    return (prio == PRIO_SRST_WINS) ? srst : (srst & ce);
  endfunction

endpackage

// File: rtl/lutram_in_stage.sv
module lutram_in_stage #(
  parameter int AW       = 6,
  parameter int DW       = 16,
  parameter bit IN_REG   = 1'b0,
  parameter bit WE_GATED = 1'b0
) (
  input  logic          clk,
  input  logic          in_ce,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] data_i,
  input  logic          we_i,
  output logic [AW-1:0] addr_o,
  output logic [DW-1:0] data_o,
  output logic          we_o
);

  generate
    if (IN_REG) begin : g_reg
      logic [AW-1:0] addr_r = '0;
      logic [DW-1:0] data_r = '0;
      logic          we_r   = 1'b0;
      logic          we_load;

      assign we_load = WE_GATED ? in_ce : 1'b1;

      always_ff @(posedge clk) begin
        if (in_ce) begin
          addr_r <= addr_i;
          data_r <= data_i;
        end
        if (we_load) begin
          we_r <= we_i;
        end
      end

      assign addr_o = addr_r;
      assign data_o = data_r;
      assign we_o   = we_r;
    end else begin : g_bare
      logic unused_in;
      assign unused_in = ^{clk, in_ce};
      assign addr_o = addr_i;
      assign data_o = data_i;
      assign we_o   = we_i;
    end
  endgenerate

endmodule

// File: rtl/lutram_array.sv
module lutram_array #(
  parameter int             DEPTH     = 64,
  parameter int             AW        = 6,
  parameter int             DW        = 16,
  parameter logic [DW-1:0]  INIT_WORD = '0
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);

  localparam logic [AW:0] DEPTH_W = (AW+1)'(DEPTH);

  logic [DW-1:0] mem [DEPTH];
  logic          in_range;

  initial begin
    for (int i = 0; i < DEPTH; i++) begin
      mem[i] = INIT_WORD;
    end
  end

  assign in_range = ({1'b0, addr} < DEPTH_W);

  always_ff @(posedge clk) begin
    if (we && in_range) begin
      mem[addr] <= wdata;
    end
  end

  assign rdata = in_range ? mem[addr] : INIT_WORD;

endmodule

// File: rtl/lutram_out_stage.sv
module lutram_out_stage #(
  parameter int                     DW        = 16,
  parameter bit                     PIPE_EN   = 1'b0,
  parameter lutram_pkg::srst_prio_e SRST_PRIO = lutram_pkg::PRIO_SRST_WINS
) (
  input  logic          clk,
  input  logic          arst,
  input  logic          srst,
  input  logic          ce,
  input  logic [DW-1:0] d,
  output logic [DW-1:0] q
);

  logic          clr;
  logic [DW-1:0] s1 = '0;

  assign clr = lutram_pkg::clear_hits(SRST_PRIO, srst, ce);

  always_ff @(posedge clk or posedge arst) begin
    if (arst)        s1 <= '0;
    else if (clr)    s1 <= '0;
    else if (ce)     s1 <= d;
  end

  generate
    if (PIPE_EN) begin : g_pipe
      logic [DW-1:0] s2 = '0;
      always_ff @(posedge clk or posedge arst) begin
        if (arst)      s2 <= '0;
        else if (clr)  s2 <= '0;
        else if (ce)   s2 <= s1;
      end
      assign q = s2;
    end else begin : g_single
      assign q = s1;
    end
  endgenerate

endmodule

// File: rtl/lutram_sp.sv
module lutram_sp #(
  parameter int                     DEPTH     = 64,
  parameter int                     WIDTH     = 16,
  parameter bit                     IN_REG    = 1'b0,
  parameter bit                     WE_GATED  = 1'b0,
  parameter bit                     PIPE_EN   = 1'b0,
  parameter lutram_pkg::srst_prio_e SRST_PRIO = lutram_pkg::PRIO_SRST_WINS,
  parameter logic [WIDTH-1:0]       INIT_WORD = '0,
  localparam int                    AW        = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             in_ce,
  input  logic [AW-1:0]    addr,
  input  logic [WIDTH-1:0] din,
  input  logic             wr_en,
  input  logic             oreg_ce,
  input  logic             oreg_srst,
  input  logic             oreg_arst,
  output logic [WIDTH-1:0] rd_comb,
  output logic [WIDTH-1:0] rd_q
);

  logic [AW-1:0]    eff_addr;
  logic [WIDTH-1:0] eff_data;
  logic             eff_we;

  lutram_in_stage #(
    .AW(AW), .DW(WIDTH), .IN_REG(IN_REG), .WE_GATED(WE_GATED)
  ) u_in (
    .clk(clk), .in_ce(in_ce),
    .addr_i(addr), .data_i(din), .we_i(wr_en),
    .addr_o(eff_addr), .data_o(eff_data), .we_o(eff_we)
  );

  lutram_array #(
    .DEPTH(DEPTH), .AW(AW), .DW(WIDTH), .INIT_WORD(INIT_WORD)
  ) u_arr (
    .clk(clk), .we(eff_we), .addr(eff_addr), .wdata(eff_data), .rdata(rd_comb)
  );

  lutram_out_stage #(
    .DW(WIDTH), .PIPE_EN(PIPE_EN), .SRST_PRIO(SRST_PRIO)
  ) u_out (
    .clk(clk), .arst(oreg_arst), .srst(oreg_srst), .ce(oreg_ce),
    .d(rd_comb), .q(rd_q)
  );

endmodule

// File: rtl/lutram_sp_chk.sv
module lutram_sp_chk #(
  parameter int                     DEPTH     = 64,
  parameter int                     WIDTH     = 16,
  parameter bit                     IN_REG    = 1'b0,
  parameter bit                     PIPE_EN   = 1'b0,
  parameter lutram_pkg::srst_prio_e SRST_PRIO = lutram_pkg::PRIO_SRST_WINS,
  localparam int                    AW        = $clog2(DEPTH)
) (
  input logic             clk,
  input logic             in_ce,
  input logic [AW-1:0]    addr,
  input logic [WIDTH-1:0] din,
  input logic             wr_en,
  input logic             oreg_ce,
  input logic             oreg_srst,
  input logic             oreg_arst,
  input logic [WIDTH-1:0] rd_comb,
  input logic [WIDTH-1:0] rd_q
);

  localparam bit WINS = (SRST_PRIO == lutram_pkg::PRIO_SRST_WINS);

  logic unused_chk;
  assign unused_chk = in_ce;

  AST_ARST_ZERO: assert property (@(posedge clk)
    oreg_arst |-> rd_q == '0); // R10

  AST_CE_HOLD: assert property (@(posedge clk) disable iff (oreg_arst)
    (!oreg_ce && !(WINS && oreg_srst)) |=> $stable(rd_q)); // R7

  generate
    if (WINS) begin : g_wins
      AST_SRST_WINS: assert property (@(posedge clk) disable iff (oreg_arst)
        oreg_srst |=> rd_q == '0); // R8
    end else begin : g_gates
      AST_SRST_GATED: assert property (@(posedge clk) disable iff (oreg_arst)
        (oreg_srst && oreg_ce) |=> rd_q == '0); // R9
    end

    if (PIPE_EN) begin : g_p2
      AST_PIPE_LAT: assert property (@(posedge clk) disable iff (oreg_arst)
        (oreg_ce && !oreg_srst && $past(oreg_ce && !oreg_srst && !oreg_arst))
          |=> rd_q == $past(rd_comb, 2)); // R4
    end else begin : g_p1
      AST_REG_LAT: assert property (@(posedge clk) disable iff (oreg_arst)
        (oreg_ce && !oreg_srst) |=> rd_q == $past(rd_comb)); // R3
    end

    if (!IN_REG) begin : g_bare
      AST_WRITE_SEEN: assert property (@(posedge clk)
        wr_en |=> (addr != $past(addr) || rd_comb == $past(din))); // R1
    end else begin : g_regd
      logic unused_bare;
      assign unused_bare = ^{addr, din, wr_en};
    end
  endgenerate

endmodule

bind lutram_sp lutram_sp_chk #(
  .DEPTH(DEPTH), .WIDTH(WIDTH), .IN_REG(IN_REG), .PIPE_EN(PIPE_EN), .SRST_PRIO(SRST_PRIO)
) u_chk (
  .clk(clk), .in_ce(in_ce), .addr(addr), .din(din), .wr_en(wr_en),
  .oreg_ce(oreg_ce), .oreg_srst(oreg_srst), .oreg_arst(oreg_arst),
  .rd_comb(rd_comb), .rd_q(rd_q)
);

// File: tb/lutram_sp_bench.sv
`timescale 1ns/1ps
module lutram_sp_bench;

  localparam int DEPTH = 64;
  localparam int W     = 16;
  localparam int AW    = 6;

  localparam bit          C_INREG [3] = '{1'b0, 1'b1, 1'b1};
  localparam bit          C_WEGAT [3] = '{1'b0, 1'b0, 1'b1};
  localparam bit          C_PIPE  [3] = '{1'b0, 1'b1, 1'b0};
  localparam bit          C_WINS  [3] = '{1'b1, 1'b0, 1'b1};
  localparam logic [W-1:0] C_INIT [3] = '{16'h0000, 16'hA5C3, 16'h0F0F};

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic          in_ce = 1'b0;
  logic [AW-1:0] addr  = '0;
  logic [W-1:0]  din   = '0;
  logic          wr_en = 1'b0;
  logic          oce   = 1'b0;
  logic          srst  = 1'b0;
  logic          arst  = 1'b0;

  logic [W-1:0] comb [3];
  logic [W-1:0] q    [3];

  lutram_sp #(.DEPTH(DEPTH), .WIDTH(W), .IN_REG(1'b0), .WE_GATED(1'b0), .PIPE_EN(1'b0),
              .SRST_PRIO(lutram_pkg::PRIO_SRST_WINS), .INIT_WORD(16'h0000)) u_lutram_sp (
    .clk(clk), .in_ce(in_ce), .addr(addr), .din(din), .wr_en(wr_en), .oreg_ce(oce),
    .oreg_srst(srst), .oreg_arst(arst), .rd_comb(comb[0]), .rd_q(q[0]));

  lutram_sp #(.DEPTH(DEPTH), .WIDTH(W), .IN_REG(1'b1), .WE_GATED(1'b0), .PIPE_EN(1'b1),
              .SRST_PRIO(lutram_pkg::PRIO_CE_GATES), .INIT_WORD(16'hA5C3)) u_lutram_sp_b (
    .clk(clk), .in_ce(in_ce), .addr(addr), .din(din), .wr_en(wr_en), .oreg_ce(oce),
    .oreg_srst(srst), .oreg_arst(arst), .rd_comb(comb[1]), .rd_q(q[1]));

  lutram_sp #(.DEPTH(DEPTH), .WIDTH(W), .IN_REG(1'b1), .WE_GATED(1'b1), .PIPE_EN(1'b0),
              .SRST_PRIO(lutram_pkg::PRIO_SRST_WINS), .INIT_WORD(16'h0F0F)) u_lutram_sp_c (
    .clk(clk), .in_ce(in_ce), .addr(addr), .din(din), .wr_en(wr_en), .oreg_ce(oce),
    .oreg_srst(srst), .oreg_arst(arst), .rd_comb(comb[2]), .rd_q(q[2]));

  // Reference state, updated from the requirements only.
  logic [W-1:0]  m_mem [3][DEPTH];
  logic [AW-1:0] m_ra  [3];
  logic [W-1:0]  m_rd  [3];
  logic          m_rw  [3];
  logic [W-1:0]  m_q1  [3];
  logic [W-1:0]  m_q2  [3];

  int    n_chk = 0;
  int    n_err = 0;
  bit    done  = 1'b0;
  string tc, tq;

  function automatic logic [AW-1:0] eff_a(int k);
    return C_INREG[k] ? m_ra[k] : addr;
  endfunction

  task automatic chk(string tag, int k, logic [W-1:0] act, logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s dut%0d actual=%h expected=%h t=%0t", tag, k, act, exp, $time);
    end
  endtask

  task automatic model_edge();
    for (int k = 0; k < 3; k++) begin
      logic [AW-1:0] ea;
      logic [W-1:0]  ed, rv;
      logic          ew, clr;
      ea  = eff_a(k);
      ed  = C_INREG[k] ? m_rd[k] : din;
      ew  = C_INREG[k] ? m_rw[k] : wr_en;
      rv  = m_mem[k][ea];
      clr = C_WINS[k] ? srst : (srst && oce);
      if (arst || clr) begin
        m_q1[k] = '0; m_q2[k] = '0;
      end else if (oce) begin
        m_q2[k] = m_q1[k]; m_q1[k] = rv;
      end
      if (ew) m_mem[k][ea] = ed;
      if (in_ce) begin
        m_ra[k] = addr; m_rd[k] = din;
      end
      if (!C_WEGAT[k] || in_ce) m_rw[k] = wr_en;
    end
  endtask

  task automatic step(logic [AW-1:0] a, logic [W-1:0] d, logic we, logic ice,
                      logic oc, logic sr, logic ar);
    @(negedge clk);
    addr = a; din = d; wr_en = we; in_ce = ice; oce = oc; srst = sr; arst = ar;
    if (ar) for (int k = 0; k < 3; k++) begin m_q1[k] = '0; m_q2[k] = '0; end
    #1;
    for (int k = 0; k < 3; k++) begin
      string t;
      if (tq == "SRST")                t = C_WINS[k] ? "R8" : "R9";
      else if (tq == "R3" && C_PIPE[k]) t = "R4";
      else                             t = tq;
      chk(tc, k, comb[k], m_mem[k][eff_a(k)]);
      chk(t,  k, q[k], C_PIPE[k] ? m_q2[k] : m_q1[k]);
    end
    @(posedge clk);
    model_edge();
  endtask

  function automatic logic [W-1:0] rw16();
    return W'($urandom);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1357_2468));
    for (int k = 0; k < 3; k++) begin
      for (int i = 0; i < DEPTH; i++) m_mem[k][i] = C_INIT[k];
      m_ra[k] = '0; m_rd[k] = '0; m_rw[k] = 1'b0; m_q1[k] = '0; m_q2[k] = '0;
    end

    // Reset state and start-up contents.
    tc = "R11"; tq = "R10";
    step(0, 0, 0, 0, 0, 0, 1);
    step(0, 0, 0, 0, 0, 0, 1);
    tq = "R3";
    for (int i = 0; i < 8; i++) step(AW'(i * 5 + 3), rw16(), 0, 1, 1, 0, 0);

    // Writes at scattered addresses.
    tc = "R1";
    for (int i = 0; i < 40; i++) step(AW'($urandom), rw16(), 1, 1, 1, 0, 0);

    // Same address written back to back: new word on comb, old word registered.
    tc = "R2";
    for (int i = 0; i < 6; i++) step(6'd9, rw16(), 1, 1, 1, 0, 0);

    // Input enable low: registered address/data hold.
    tc = "R5";
    for (int i = 0; i < 6; i++) step(AW'($urandom), rw16(), 0, 0, 1, 0, 0);

    // Input enable low with write enable high: gated vs ungated WE register.
    tc = "R6";
    for (int i = 0; i < 6; i++) step(AW'($urandom), rw16(), 1, 0, 1, 0, 0);
    for (int i = 0; i < 3; i++) step(6'd9, rw16(), 0, 0, 1, 0, 0);

    // Output enable low: outputs hold while writes continue.
    tc = "R1"; tq = "R7";
    for (int i = 0; i < 8; i++) step(AW'($urandom), rw16(), 1, 1, 0, 0, 0);

    // Synchronous clear with enable low, then high.
    tq = "SRST";
    for (int i = 0; i < 4; i++) step(AW'($urandom), rw16(), 1, 1, 0, 1, 0);
    for (int i = 0; i < 2; i++) step(AW'($urandom), rw16(), 1, 1, 1, 1, 0);
    tq = "R3";
    for (int i = 0; i < 4; i++) step(AW'($urandom), rw16(), 1, 1, 1, 0, 0);

    // Asynchronous clear mid-stream; contents stay.
    tc = "R10"; tq = "R10";
    step(6'd9, 0, 0, 1, 1, 0, 1);
    tc = "R2"; tq = "R3";
    for (int i = 0; i < 3; i++) step(6'd9, 0, 0, 1, 1, 0, 0);

    // Mixed random traffic.
    for (int i = 0; i < 400; i++) begin
      step(AW'($urandom), rw16(), ($urandom % 2) == 0, ($urandom % 4) != 0,
           ($urandom % 8) != 0, ($urandom % 20) == 0, ($urandom % 50) == 0);
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule